// File: doc/BRIEF.md
# AES-128 Round Key Generator

This block takes one 128-bit cipher key and produces the ten 128-bit round keys that a ten-round AES-128 encryption datapath consumes. It also presents the cipher key itself as round key 0. The encryption controller loads a key and then requests the next key once per round. The block answers with the round index, the four 32-bit words of that round key and a valid flag.

A build-time parameter selects how the keys are made. In the first mode, each key is derived from the previous one at the moment it is requested, so it advances in lockstep with the round counter and needs only one 128-bit register. In the second mode, all eleven keys are computed into a register bank straight after a load, and requests then only step a read pointer. Both modes have the same ports. After valid rises, both give the same key for the same sequence of requests.

Top module: `aes_rkey_gen`

## Requirements
- R1: After reset, `valid_o` is 0, `round_o` is 0 and `err_o` is 0.
- R2: A load sets `round_o` to 0 on the next cycle, clears `err_o` and makes `rkey_o` equal to the loaded key. In lockstep mode (`PRECOMP`=0), `valid_o` is 1 on the next cycle. In precompute mode (`PRECOMP`=1), `valid_o` is 0 on the next cycle and rises within 11 cycles of the load. A load in the middle of a sequence restarts it.
- R3: Word j of a round key is `rkey_o[127-32*j -: 32]`, so word 0 sits in the top bits, and each word is stored with its first byte in its top byte. For key 2b7e151628aed2a6abf7158809cf4f3c, round key 1 is a0fafe1788542cb123a339392a6c7605.
- R4: New word 0 is old word 0 xor T. T is old word 3 rotated left by one byte, passed through the AES S-box byte by byte, then xored with the round constant in its top byte. Each new word j>0 is old word j xor new word j-1.
- R5: The round constants for rounds 1 to 10 are 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36. For the all-zero key, round key 1 is 62636363 repeated four times, and round key 10 is b4ef5bcb3e92e21123e951cf6f8f188e.
- R6: A next request with `valid_o`=1 and `round_o`<10 raises `round_o` by 1 on the next cycle and outputs that round's key.
- R7: A next request at round 10 keeps `round_o` and `rkey_o` unchanged and sets `err_o`. `err_o` stays set until the next load.
- R8: A next request while `valid_o`=0 has no effect on `round_o`. This covers requests before the first load and requests while the bank is still filling.
- R9: When load and next arrive in the same cycle, the load wins.
- R10: Once valid, both modes give the same `round_o` and `rkey_o` for the same request sequence.
- R11: For key 2b7e151628aed2a6abf7158809cf4f3c, round key 10 is d014f9a8c9ee2589e13f0cc8b6630ca6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load `key_i` and restart at round 0 |
| key_i | input | 128 | Cipher key, word 0 in the top bits |
| next_i | input | 1 | Request the next round key |
| round_o | output | 4 | Index of the key on `rkey_o` |
| rkey_o | output | 128 | Current round key, words 0 to 3 from the top |
| valid_o | output | 1 | `rkey_o` and `round_o` are meaningful |
| err_o | output | 1 | Sticky: a request was made past round 10 |

## Verification
The hardest state to reach is a precompute instance that receives requests while its bank is only partly filled. The bench pulses next in the middle of the fill and then checks that round 0 is still shown once valid rises. It also drives both modes side by side through full ten-round sweeps over several keys. Those sweeps include requests past round 10, a load issued together with a next, and a reload halfway through a sequence. Expected keys come from a reference S-box in the bench, which is generated by a logarithm walk over the field rather than by inversion.

// File: rtl/aes_rkey_pkg.sv
package aes_rkey_pkg;

    localparam int NUM_ROUNDS = 10;
    localparam int RND_W      = $clog2(NUM_ROUNDS + 1);
    localparam int KEY_W      = 128;
    localparam int WORD_W     = 32;

    // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_x2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = gf_x2(p);
        end
        return acc;
    endfunction

    // S-box: multiplicative inverse (a^254) followed by the affine map
    function automatic logic [7:0] sbox_f(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] p;
        logic [7:0] e;
        r = 8'h01;
        p = a;
        e = 8'd254;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        if (a == 8'h00) r = 8'h00;
        return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
                 ^ {r[3:0], r[7:4]} ^ 8'h63;
    endfunction

    // round constant for round n (1-based)
    function automatic logic [7:0] rcon_f(input logic [RND_W-1:0] n);
        logic [7:0] c;
        c = 8'h01;
        for (int i = 2; i <= NUM_ROUNDS; i++) begin
            if (i <= int'(n)) c = gf_x2(c);
        end
        return c;
    endfunction

endpackage

// File: rtl/aes_rkey_sbox.sv
module aes_rkey_sbox
    import aes_rkey_pkg::*;
(
    input  logic [7:0] byte_i,
    output logic [7:0] byte_o
);
    always_comb begin
        byte_o = sbox_f(byte_i);
    end
endmodule

// File: rtl/aes_rkey_step.sv
module aes_rkey_step
    import aes_rkey_pkg::*;
(
    input  logic [KEY_W-1:0] key_i,
    input  logic [RND_W-1:0] rnd_i,
    output logic [KEY_W-1:0] key_o
);
    localparam int NWORDS = KEY_W / WORD_W;

    logic [WORD_W-1:0] w_old [NWORDS];
    logic [WORD_W-1:0] w_new [NWORDS];
    logic [WORD_W-1:0] rot_w;
    logic [WORD_W-1:0] sub_w;
    logic [WORD_W-1:0] mix_w;

    assign rot_w = {w_old[NWORDS-1][WORD_W-9:0], w_old[NWORDS-1][WORD_W-1 -: 8]};

    for (genvar g = 0; g < WORD_W / 8; g++) begin : g_sub
        aes_rkey_sbox u_sbox (
            .byte_i (rot_w[8*g +: 8]),
            .byte_o (sub_w[8*g +: 8])
        );
    end

    assign mix_w = sub_w ^ {rcon_f(rnd_i), {(WORD_W-8){1'b0}}};

    for (genvar j = 0; j < NWORDS; j++) begin : g_word
        assign w_old[j] = key_i[KEY_W-1-WORD_W*j -: WORD_W];
        if (j == 0) begin : g_first
            assign w_new[j] = w_old[j] ^ mix_w;
        end else begin : g_chain
            assign w_new[j] = w_old[j] ^ w_new[j-1];
        end
        assign key_o[KEY_W-1-WORD_W*j -: WORD_W] = w_new[j];
    end
endmodule

// File: rtl/aes_rkey_gen.sv
module aes_rkey_gen
    import aes_rkey_pkg::*;
#(
    parameter int PRECOMP = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             next_i,
    output logic [RND_W-1:0] round_o,
    output logic [KEY_W-1:0] rkey_o,
    output logic             valid_o,
    output logic             err_o
);
    localparam logic [RND_W-1:0] LAST = RND_W'(NUM_ROUNDS);

    logic [KEY_W-1:0] step_in;
    logic [RND_W-1:0] step_rnd;
    logic [KEY_W-1:0] step_out;

    aes_rkey_step u_step (
        .key_i (step_in),
        .rnd_i (step_rnd),
        .key_o (step_out)
    );

    if (PRECOMP == 0) begin : g_lockstep
        typedef struct packed {
            logic [KEY_W-1:0] key;
            logic [RND_W-1:0] round;
            logic             valid;
            logic             err;
        } ls_state_t;

        ls_state_t s_d, s_q;

        assign step_in  = s_q.key;
        assign step_rnd = s_q.round + RND_W'(1);

        always_comb begin
            s_d = s_q;
            if (load_i) begin
                s_d.key   = key_i;
                s_d.round = '0;
                s_d.valid = 1'b1;
                s_d.err   = 1'b0;
            end else if (next_i && s_q.valid) begin
                if (s_q.round < LAST) begin
                    s_d.key   = step_out;
                    s_d.round = s_q.round + RND_W'(1);
                end else begin
                    s_d.err = 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign round_o = s_q.round;
        assign rkey_o  = s_q.key;
        assign valid_o = s_q.valid;
        assign err_o   = s_q.err;
    end else begin : g_precomp
        typedef struct packed {
            logic [NUM_ROUNDS:0][KEY_W-1:0] bank;
            logic [RND_W-1:0]               fill;
            logic                           busy;
            logic [RND_W-1:0]               round;
            logic                           valid;
            logic                           err;
        } pc_state_t;

        pc_state_t        s_d, s_q;
        logic [RND_W-1:0] prev_idx;

        assign prev_idx = (s_q.fill == '0) ? '0 : s_q.fill - RND_W'(1);
        assign step_in  = s_q.bank[prev_idx];
        assign step_rnd = s_q.fill;

        always_comb begin
            s_d = s_q;
            if (load_i) begin
                s_d.bank[0] = key_i;
                s_d.fill    = RND_W'(1);
                s_d.busy    = 1'b1;
                s_d.round   = '0;
                s_d.valid   = 1'b0;
                s_d.err     = 1'b0;
            end else if (s_q.busy) begin
                s_d.bank[s_q.fill] = step_out;
                if (s_q.fill == LAST) begin
                    s_d.busy  = 1'b0;
                    s_d.valid = 1'b1;
                end else begin
                    s_d.fill = s_q.fill + RND_W'(1);
                end
            end else if (next_i && s_q.valid) begin
                if (s_q.round < LAST) s_d.round = s_q.round + RND_W'(1);
                else                  s_d.err   = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign round_o = s_q.round;
        assign rkey_o  = s_q.bank[s_q.round];
        assign valid_o = s_q.valid;
        assign err_o   = s_q.err;
    end
endmodule

// File: rtl/aes_rkey_gen_chk.sv
module aes_rkey_gen_chk
    import aes_rkey_pkg::*;
#(
    parameter int PRECOMP = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic [KEY_W-1:0] key_i,
    input logic             next_i,
    input logic [RND_W-1:0] round_o,
    input logic [KEY_W-1:0] rkey_o,
    input logic             valid_o,
    input logic             err_o
);
    localparam logic [RND_W-1:0] LAST = RND_W'(NUM_ROUNDS);

    // R2
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (round_o == '0) && !err_o);

    // R6
    round_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && next_i && valid_o && round_o < LAST)
        |=> round_o == $past(round_o) + RND_W'(1));

    // R7
    end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && next_i && valid_o && round_o == LAST)
        |=> (round_o == LAST) && $stable(rkey_o) && err_o);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !load_i) |=> err_o);

    // R8
    idle_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !load_i) |=> $stable(round_o));

    // R6
    round_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        round_o <= LAST);

    if (PRECOMP == 0) begin : g_ls
        // R2
        ls_load_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load_i |=> valid_o && (rkey_o == $past(key_i)));
    end else begin : g_pc
        // R2
        pc_load_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load_i |=> !valid_o);
    end
endmodule

bind aes_rkey_gen aes_rkey_gen_chk #(.PRECOMP(PRECOMP)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .key_i   (key_i),
    .next_i  (next_i),
    .round_o (round_o),
    .rkey_o  (rkey_o),
    .valid_o (valid_o),
    .err_o   (err_o)
);

// File: tb/aes_rkey_gen_bench.sv
`timescale 1ns/1ps
module aes_rkey_gen_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [127:0] key_i = '0;
    logic         next_i = 1'b0;
    logic [3:0]   rnd_a, rnd_b;
    logic [127:0] key_a, key_b;
    logic         val_a, val_b, err_a, err_b;

    int total = 0;
    int bad = 0;
    logic [7:0]   sb [256];
    logic [127:0] ref_k [11];

    always #2.5 clk = ~clk;

    aes_rkey_gen #(.PRECOMP(0)) u_aes_rkey_gen (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i), .next_i(next_i),
        .round_o(rnd_a), .rkey_o(key_a), .valid_o(val_a), .err_o(err_a));

    aes_rkey_gen #(.PRECOMP(1)) u_aes_rkey_gen_pre (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .key_i(key_i), .next_i(next_i),
        .round_o(rnd_b), .rkey_o(key_b), .valid_o(val_b), .err_o(err_b));

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference S-box built by walking powers of 3 and their inverses
    task automatic build_sbox();
        logic [7:0] p, q, x;
        p = 8'h01; q = 8'h01;
        for (int n = 0; n < 255; n++) begin
            p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b00};
            q = q ^ {q[3:0], 4'h0};
            if (q[7]) q = q ^ 8'h09;
            x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
            sb[p] = x ^ 8'h63;
        end
        sb[0] = 8'h63;
    endtask

    task automatic build_ref(input logic [127:0] k);
        logic [7:0]  rc;
        logic [31:0] w0, w1, w2, w3, t;
        rc = 8'h01;
        ref_k[0] = k;
        for (int r = 1; r <= 10; r++) begin
            {w0, w1, w2, w3} = ref_k[r-1];
            t = {sb[w3[23:16]], sb[w3[15:8]], sb[w3[7:0]], sb[w3[31:24]]} ^ {rc, 24'h0};
            w0 = w0 ^ t; w1 = w1 ^ w0; w2 = w2 ^ w1; w3 = w3 ^ w2;
            ref_k[r] = {w0, w1, w2, w3};
            rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
        end
    endtask

    task automatic pulse_load(input logic [127:0] k, input logic with_next);
        key_i = k; load_i = 1'b1; next_i = with_next;
        @(negedge clk);
        load_i = 1'b0; next_i = 1'b0;
    endtask

    task automatic pulse_next();
        next_i = 1'b1;
        @(negedge clk);
        next_i = 1'b0;
    endtask

    task automatic wait_pre(input string tag);
        int n = 0;
        while (!val_b && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(tag, {124'd0, 4'(n)}, {124'd0, 4'(n <= 10 ? n : 0)});
    endtask

    // full pass over one key: load, fill, ten steps, both modes
    task automatic sweep(input logic [127:0] k);
        build_ref(k);
        pulse_load(k, 1'b0);
        chk("R2 lockstep valid/round", {123'd0, val_a, rnd_a}, {123'd0, 1'b1, 4'd0});
        chk("R2 lockstep key0", key_a, k);
        wait_pre("R2 precompute fill time");
        chk("R2 precompute key0", key_b, k);
        for (int r = 1; r <= 10; r++) begin
            pulse_next();
            chk("R6 round index", {124'd0, rnd_a}, 128'(r));
            chk("R4 lockstep key", key_a, ref_k[r]);
            chk("R10 modes agree", {key_b, 4'd0} >> 4 ^ {4'd0, rnd_b} << 124, {key_a, 4'd0} >> 4 ^ {4'd0, rnd_a} << 124);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [127:0] lf;
        build_sbox();
        repeat (3) @(negedge clk);
        // R1
        chk("R1 reset", {118'd0, val_a, val_b, err_a, err_b, rnd_a, rnd_b},
            128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: next before any load
        pulse_next();
        chk("R8 next before load", {120'd0, rnd_a, rnd_b}, 128'd0);
        chk("R8 still invalid", {126'd0, val_a, val_b}, 128'd0);

        // known-answer key
        sweep(128'h2b7e151628aed2a6abf7158809cf4f3c);
        chk("R11 round key 10", key_a, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
        chk("R11 round key 10 precompute", key_b, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
        // R7: request past the end
        pulse_next();
        chk("R7 round held", {120'd0, rnd_a, rnd_b}, {120'd0, 4'd10, 4'd10});
        chk("R7 key held", key_a, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
        chk("R7 err set", {126'd0, err_a, err_b}, 128'd3);
        @(negedge clk);
        chk("R7 err sticky", {126'd0, err_a, err_b}, 128'd3);

        // R3: round key 1 word order, via reload
        pulse_load(128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b0);
        wait_pre("R2 refill");
        chk("R2 err cleared", {126'd0, err_a, err_b}, 128'd0);
        pulse_next();
        chk("R3 word order round 1", key_a, 128'ha0fafe1788542cb123a339392a6c7605);
        chk("R3 word order round 1 precompute", key_b, 128'ha0fafe1788542cb123a339392a6c7605);

        // R9: load with next in the same cycle, all-zero key
        pulse_load(128'd0, 1'b1);
        chk("R9 load wins", {124'd0, rnd_a}, 128'd0);
        chk("R9 key loaded", key_a, 128'd0);
        // R8: next while precompute bank fills
        pulse_next();
        pulse_next();
        wait_pre("R8 fill after ignored next");
        chk("R8 precompute round during fill", {124'd0, rnd_b}, 128'd0);
        chk("R8 precompute key during fill", key_b, 128'd0);

        // R5: all-zero key round constants
        sweep(128'd0);
        chk("R5 zero key round 10", key_a, 128'hb4ef5bcb3e92e21123e951cf6f8f188e);
        pulse_load(128'd0, 1'b0);
        wait_pre("R5 refill");
        pulse_next();
        chk("R5 zero key round 1", key_a, {4{32'h62636363}});

        // R2: reload in mid-sequence
        pulse_next(); pulse_next(); pulse_next();
        pulse_load({4{32'hffffffff}}, 1'b0);
        chk("R2 mid-sequence reload", {124'd0, rnd_a}, 128'd0);
        wait_pre("R2 mid reload fill");
        chk("R2 mid-sequence precompute round", {124'd0, rnd_b}, 128'd0);

        // sweep over further keys
        sweep({4{32'hffffffff}});
        lf = 128'h0123456789abcdeffedcba9876543210;
        for (int k = 0; k < 8; k++) begin
            sweep(lf);
            lf = {lf[126:0], lf[127] ^ lf[125] ^ lf[100] ^ lf[98]} ^ 128'(k * 32'h9e3779b9);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule